// File: doc/BRIEF.md
# External Clock Pin Edge Counter Front End

This block turns an asynchronous external clock pin into a stream of count pulses for a timer that runs on the system clock. The pin is sampled once per system clock period. A half-cycle capture stage takes the pin value in the high phase of the system clock. A short chain of rising-edge registers follows it, and then an edge comparator. For every edge of the selected polarity, the block raises `count_pulse` for exactly one system clock cycle.

A timer uses this block in place of its prescaled clock taps. A 3-bit select code picks the polarity: code 7 counts rising pin edges, code 6 counts falling pin edges, and any other code produces no pulses. The `enable` input gates the output only. The synchroniser keeps following the pin while it is disabled, so an edge that happened while disabled is never emitted later. The pin may only be enabled or disabled after it has been stable for at least one cycle. Each high and low phase of the external clock must last longer than one system clock cycle.

Top module: `xpin_count_pulse`

## Requirements
- R1: While `rst_n` is low, every capture, synchroniser and history stage holds 0 and `count_pulse` is 0. After reset is released with the pin held low, `count_pulse` stays 0.
- R2: With `sel_code` = 7 and `enable` = 1, each 0-to-1 transition of the synchronised pin produces `count_pulse` = 1 for exactly one system clock cycle. A 1-to-0 transition produces nothing.
- R3: With `sel_code` = 6 and `enable` = 1, each 1-to-0 transition of the synchronised pin produces exactly one single-cycle pulse. A 0-to-1 transition produces nothing.
- R4: With any `sel_code` other than 6 or 7, `count_pulse` stays 0 whatever the pin does.
- R5: While `enable` is 0, `count_pulse` is 0. The synchroniser keeps tracking the pin, so an edge seen while disabled does not produce a pulse after `enable` returns to 1.
- R6: The pin is captured at the falling system clock edge. The pulse is high during the cycle that starts 1.5 cycles after that capture. The delay from a pin edge to the rising clock edge that ends the pulse is therefore between 2.5 and 3.5 system clock cycles. A pin change 1 ns before a falling edge produces its pulse one cycle earlier than a change 1 ns after that falling edge.
- R7: Because all stages reset to 0, releasing reset while the pin is high with code 7 and `enable` = 1 produces exactly one pulse. That pulse is high in the third cycle counted from the cycle in which reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_raw | input | 1 | Asynchronous external clock pin |
| enable | input | 1 | Count-pulse gate; 1 lets pulses through |
| sel_code | input | SEL_W | Clock-select code: 7 selects rising edges, 6 selects falling edges, other values select neither |
| count_pulse | output | 1 | One-cycle pulse per selected pin edge |

## Verification
The bench builds the block with its defaults: two rising-edge synchroniser stages after the half-cycle capture, a 3-bit select, and rising and falling codes 7 and 6. This brings the 2.5 to 3.5 cycle latency window into reach. The bench places pin edges just before and just after a falling clock edge and checks that the pulse moves by exactly one cycle. A 3-bit select also leaves spare codes, such as 5, for checking that unselected codes stay silent. The default chain depth, together with the all-zero reset, fixes the cycle in which the single pulse appears when the pin is already high at reset release.

// File: rtl/xpin_pkg.sv
package xpin_pkg;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2
  } edge_mode_e;

  localparam int unsigned DEF_SEL_W      = 3;
  localparam int unsigned DEF_RISE_CODE  = 7;
  localparam int unsigned DEF_FALL_CODE  = 6;
  localparam int unsigned DEF_SYNC_DEPTH = 2;

endpackage

// File: rtl/xpin_halfcycle_capture.sv
module xpin_halfcycle_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);

  // Captures at the end of the high phase: same observed timing as a
  // latch that is transparent while clk is high.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) q_out <= 1'b0;
    else        q_out <= d_in;
  end

endmodule

// File: rtl/xpin_sync_chain.sv
module xpin_sync_chain #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);

  localparam int unsigned LAST = DEPTH - 1;

  logic [DEPTH-1:0] stage_q;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= 1'b0;
          else        stage_q[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= 1'b0;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign q_out = stage_q[LAST];

endmodule

// File: rtl/xpin_edge_detect.sv
module xpin_edge_detect
  import xpin_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_in,
  input  logic       enable,
  input  edge_mode_e mode,
  output logic       pulse
);

  logic hist_q;
  logic went_up;
  logic went_down;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= 1'b0;
    else        hist_q <= sync_in;
  end

  assign went_up   =  sync_in & ~hist_q;
  assign went_down = ~sync_in &  hist_q;

  always_comb begin
    unique case (mode)
      EDGE_RISE: pulse = enable & went_up;
      EDGE_FALL: pulse = enable & went_down;
      default:   pulse = 1'b0;
    endcase
  end

endmodule

// File: rtl/xpin_count_pulse.sv
module xpin_count_pulse
  import xpin_pkg::*;
#(
  parameter int unsigned SEL_W      = DEF_SEL_W,
  parameter int unsigned RISE_CODE  = DEF_RISE_CODE,
  parameter int unsigned FALL_CODE  = DEF_FALL_CODE,
  parameter int unsigned SYNC_DEPTH = DEF_SYNC_DEPTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_raw,
  input  logic             enable,
  input  logic [SEL_W-1:0] sel_code,
  output logic             count_pulse
);

  localparam logic [SEL_W-1:0] RISE_SEL = SEL_W'(RISE_CODE);
  localparam logic [SEL_W-1:0] FALL_SEL = SEL_W'(FALL_CODE);

  logic       half_q;
  logic       sync_bit;
  edge_mode_e mode;

  always_comb begin
    if (sel_code == RISE_SEL)      mode = EDGE_RISE;
    else if (sel_code == FALL_SEL) mode = EDGE_FALL;
    else                           mode = EDGE_NONE;
  end

  xpin_halfcycle_capture u_half (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (pin_raw),
    .q_out (half_q)
  );

  xpin_sync_chain #(.DEPTH(SYNC_DEPTH)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (half_q),
    .q_out (sync_bit)
  );

  xpin_edge_detect u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync_in (sync_bit),
    .enable  (enable),
    .mode    (mode),
    .pulse   (count_pulse)
  );

endmodule

// File: rtl/xpin_count_pulse_chk.sv
module xpin_count_pulse_chk #(
  parameter int unsigned SEL_W     = 3,
  parameter int unsigned RISE_CODE = 7,
  parameter int unsigned FALL_CODE = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic [SEL_W-1:0] sel_code,
  input logic             sync_bit,
  input logic             count_pulse
);

  localparam logic [SEL_W-1:0] RS = SEL_W'(RISE_CODE);
  localparam logic [SEL_W-1:0] FS = SEL_W'(FALL_CODE);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> !count_pulse);

  // R2
  rise_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && sel_code == RS && $rose(sync_bit)) |-> count_pulse);

  // R2
  single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_pulse ##1 $stable(sel_code) |-> !count_pulse);

  // R3
  fall_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && sel_code == FS && $fell(sync_bit)) |-> count_pulse);

  // R4
  code_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_pulse |-> (sel_code == RS || sel_code == FS));

  // R5
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !count_pulse);

endmodule

bind xpin_count_pulse xpin_count_pulse_chk #(
  .SEL_W     (SEL_W),
  .RISE_CODE (RISE_CODE),
  .FALL_CODE (FALL_CODE)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .sel_code    (sel_code),
  .sync_bit    (sync_bit),
  .count_pulse (count_pulse)
);

// File: tb/sim_xpin_count_pulse.sv
`timescale 1ns/1ps
module sim_xpin_count_pulse;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_raw = 1'b0;
  logic       enable = 1'b1;
  logic [2:0] sel_code = 3'd7;
  logic       count_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  xpin_count_pulse u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_raw     (pin_raw),
    .enable      (enable),
    .sel_code    (sel_code),
    .count_pulse (count_pulse)
  );

  typedef struct packed {
    logic       pin;
    logic       en;
    logic [2:0] sel;
    logic       exp;
  } vec_t;

  // exp in cycle i follows pin of cycles i-3 and i-2 (R6 timing)
  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 3'd7, 1'b0},
    '{1'b1, 1'b1, 3'd7, 1'b0},
    '{1'b1, 1'b1, 3'd7, 1'b0},
    '{1'b1, 1'b1, 3'd7, 1'b1},  // R2 rise
    '{1'b0, 1'b1, 3'd7, 1'b0},
    '{1'b0, 1'b1, 3'd7, 1'b0},
    '{1'b1, 1'b1, 3'd7, 1'b0},  // R2 fall ignored
    '{1'b0, 1'b1, 3'd7, 1'b0},
    '{1'b0, 1'b1, 3'd6, 1'b0},  // R3 rise ignored
    '{1'b0, 1'b1, 3'd6, 1'b1},  // R3 fall
    '{1'b1, 1'b1, 3'd6, 1'b0},
    '{1'b1, 1'b1, 3'd6, 1'b0},
    '{1'b0, 1'b0, 3'd7, 1'b0},  // R5 gated rise
    '{1'b0, 1'b1, 3'd7, 1'b0},  // R5 no late pulse
    '{1'b1, 1'b1, 3'd7, 1'b0},
    '{1'b1, 1'b1, 3'd6, 1'b0},
    '{1'b0, 1'b1, 3'd5, 1'b0},  // R4 unused code
    '{1'b0, 1'b1, 3'd7, 1'b0},
    '{1'b1, 1'b1, 3'd6, 1'b1},  // R3 fall
    '{1'b0, 1'b1, 3'd7, 1'b0},
    '{1'b0, 1'b1, 3'd7, 1'b1},  // R2 rise
    '{1'b0, 1'b1, 3'd7, 1'b0},
    '{1'b0, 1'b1, 3'd7, 1'b0}
  };

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: count_pulse=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic settle(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
  endtask

  initial begin
    // R1 reset state
    settle(2);
    #15 chk(count_pulse, 1'b0, "R1 in reset");
    @(posedge clk); #2 rst_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      #13 chk(count_pulse, 1'b0, "R1 after release");
      @(posedge clk); #2;
    end

    // vector table
    for (int i = 0; i < NV; i++) begin
      @(posedge clk); #2;
      pin_raw = VEC[i].pin; enable = VEC[i].en; sel_code = VEC[i].sel;
      #13 chk(count_pulse, VEC[i].exp, $sformatf("R2/R3/R4/R5 vector %0d", i));
    end

    // R6 early: change 1 ns before falling edge
    @(posedge clk); #2 pin_raw = 1'b0; enable = 1'b1; sel_code = 3'd7;
    settle(5);
    #9 pin_raw = 1'b1;
    #16 chk(count_pulse, 1'b0, "R6 early +1");
    #20 chk(count_pulse, 1'b1, "R6 early +2");
    #20 chk(count_pulse, 1'b0, "R6 early +3");
    @(posedge clk); #2 pin_raw = 1'b0;
    settle(5);
    // R6 late: change 1 ns after falling edge
    #11 pin_raw = 1'b1;
    #34 chk(count_pulse, 1'b0, "R6 late +2");
    #20 chk(count_pulse, 1'b1, "R6 late +3");
    #20 chk(count_pulse, 1'b0, "R6 late +4");

    // R7 pin high at reset release
    @(posedge clk); #2 rst_n = 1'b0; pin_raw = 1'b1; enable = 1'b1; sel_code = 3'd7;
    settle(2);
    @(posedge clk); #2 rst_n = 1'b1;
    #13 chk(count_pulse, 1'b0, "R7 cycle 0");
    @(posedge clk); #15 chk(count_pulse, 1'b0, "R7 cycle 1");
    @(posedge clk); #15 chk(count_pulse, 1'b1, "R7 cycle 2");
    @(posedge clk); #15 chk(count_pulse, 1'b0, "R7 cycle 3");
    @(posedge clk); #15 chk(count_pulse, 1'b0, "R7 cycle 4");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    settle(5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: done=0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule